// File: doc/BRIEF.md
# Battery-free SRAM backup sequencer

This block manages a small SRAM array that has a nonvolatile shadow copy of the same size. While the supply is healthy it serves ordinary single-word reads and writes. It copies the whole SRAM into the shadow (a backup) in two cases: on a software request, or on its own when the supply starts to fail. After a deep supply dip it copies the shadow back (a restore) once the supply has recovered. Both arrays are plain synchronous single-port memories. All durations are counted in clock cycles.

Power state reaches the block as two digital flags. `pwr_ok` means the supply is above the switching threshold. `pwr_low` means it has fallen below the reset threshold. A backup runs for `T_STORE` cycles and a restore runs for `T_RECALL` cycles. A restore first zeroes every SRAM word and then fills each word from the shadow. `busy` is high whenever the block is not serving accesses. A request that arrives during that time is dropped, and no response is given for it.

Top module: `nvs_ctrl`

## Requirements
- R1: After reset, `busy` is 1 and `rsp_ready` is 0, and a restore is already pending. The first cycle that sees `pwr_ok`=1 with `pwr_low`=0 starts that restore. `busy` then falls T_RECALL+1 clock edges after that cycle.
- R2: A restore leaves every SRAM word equal to the matching shadow word and does not change the shadow. Repeated restores give the same contents. `busy` falls T_RECALL+1 edges after the cycle that started the restore.
- R3: A request sampled while `busy`=1 is refused. The next cycle has `rsp_ready`=0, and a refused write leaves the SRAM unchanged.
- R4: A request sampled with `busy`=0 and `req_valid`=1 is accepted, and `rsp_ready` is 1 in the next cycle. For a read (`req_we`=0), `rsp_rdata` in that cycle holds the addressed word. For a write (`req_we`=1), the word takes `req_wdata`. When no request is sampled, `rsp_ready` is 0 in the next cycle.
- R5: A `sw_store` pulse sampled with `busy`=0 and `pwr_ok`=1 copies the SRAM into the shadow, even if no write has happened. `busy` falls T_STORE+1 edges after the pulse.
- R6: A `sw_store` pulse sampled while `pwr_ok`=0 is ignored. `busy` stays 0 and the shadow is unchanged.
- R7: A falling edge of `pwr_ok` seen with `busy`=0 starts a backup (`busy` for T_STORE+1 edges) only if a write has been accepted since the last backup or restore finished. Without such a write, `busy` stays 0.
- R8: An accepted write marks the block dirty. The mark clears when any backup or restore finishes.
- R9: `pwr_low`=1 latches a restore request, and `busy` is 1 in the next cycle. The restore does not start while `pwr_ok`=0 or `pwr_low`=1. If `pwr_ok` rises without such a request, no restore starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Supply above switching threshold |
| pwr_low | input | 1 | Supply below reset threshold |
| sw_store | input | 1 | Software backup request, one-cycle pulse |
| req_valid | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| busy | output | 1 | Backup, restore or wait for power in progress |
| rsp_ready | output | 1 | Previous-cycle request was accepted |
| rsp_rdata | output | DW | Read data, valid when rsp_ready follows a read |

## Verification
The bench aims at the dirty gating of the power-fail backup. It causes a supply fall right after a backup and right after a restore; a design that forgets to clear the mark would raise `busy` and spend T_STORE cycles where none are due. A restore is held off by keeping `pwr_low` asserted after `pwr_ok` has returned; a design that starts on `pwr_ok` alone would drop `busy` too early. Software backups at low supply are followed by a restore that must return the older shadow contents. Random writes are issued throughout every busy window; a design that lets them through would corrupt the words read back later.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    ST_WAIT   = 2'd0,
    ST_RECALL = 2'd1,
    ST_READY  = 2'd2,
    ST_STORE  = 2'd3
  } nvs_state_e;
endpackage

// File: rtl/nvs_spram.sv
// Single-port synchronous memory, read-first, registered read port.
module nvs_spram #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/nvs_seq.sv
// Sequencer: power tracking, pending-restore latch, dirty mark, phase timer.
module nvs_seq
  import nvs_pkg::*;
#(
  parameter int T_STORE  = 12,
  parameter int T_RECALL = 20,
  parameter int CW       = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_ok,
  input  logic          pwr_low,
  input  logic          sw_store,
  input  logic          acc_wr,
  output nvs_state_e    state,
  output logic [CW-1:0] cnt,
  output logic          busy,
  output logic          dirty
);
  localparam logic [CW-1:0] STO_LAST = CW'(T_STORE - 1);
  localparam logic [CW-1:0] REC_LAST = CW'(T_RECALL - 1);

  nvs_state_e    state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          pend_q, pend_n;
  logic          dirty_q, dirty_n;
  logic          pwr_ok_q;
  logic          busy_q;
  logic          fall;

  always_comb begin
    fall    = pwr_ok_q & ~pwr_ok;
    pend_n  = pend_q | pwr_low;
    dirty_n = dirty_q | acc_wr;
    state_n = state_q;
    cnt_n   = cnt_q + CW'(1);
    unique case (state_q)
      ST_WAIT: begin
        cnt_n = '0;
        if (pwr_ok && !pwr_low) begin
          state_n = ST_RECALL;
          pend_n  = 1'b0;
        end
      end
      ST_RECALL: begin
        if (cnt_q == REC_LAST) begin
          cnt_n   = '0;
          dirty_n = 1'b0;
          state_n = pend_n ? ST_WAIT : ST_READY;
        end
      end
      ST_READY: begin
        cnt_n = '0;
        if (fall && dirty_n)          state_n = ST_STORE;
        else if (pend_n)              state_n = ST_WAIT;
        else if (sw_store && pwr_ok)  state_n = ST_STORE;
      end
      ST_STORE: begin
        if (cnt_q == STO_LAST) begin
          cnt_n   = '0;
          dirty_n = 1'b0;
          state_n = pend_n ? ST_WAIT : ST_READY;
        end
      end
      default: state_n = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_WAIT;
      cnt_q    <= '0;
      pend_q   <= 1'b1;
      dirty_q  <= 1'b0;
      pwr_ok_q <= 1'b0;
      busy_q   <= 1'b1;
    end else begin
      state_q  <= state_n;
      cnt_q    <= cnt_n;
      pend_q   <= pend_n;
      dirty_q  <= dirty_n;
      pwr_ok_q <= pwr_ok;
      busy_q   <= (state_n != ST_READY);
    end
  end

  assign state = state_q;
  assign cnt   = cnt_q;
  assign busy  = busy_q;
  assign dirty = dirty_q;
endmodule

// File: rtl/nvs_xfer.sv
// Port steering for both arrays: host access, restore (clear then copy), backup.
module nvs_xfer
  import nvs_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 8,
  parameter int CW = 5
) (
  input  nvs_state_e    state,
  input  logic [CW-1:0] cnt,
  input  logic          acc,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] s_rdata,
  input  logic [DW-1:0] h_rdata,
  output logic          s_en,
  output logic          s_we,
  output logic [AW-1:0] s_addr,
  output logic [DW-1:0] s_wdata,
  output logic          h_en,
  output logic          h_we,
  output logic [AW-1:0] h_addr,
  output logic [DW-1:0] h_wdata
);
  localparam int            DEPTH = 1 << AW;
  localparam logic [CW-1:0] D_C   = CW'(DEPTH);
  localparam logic [CW-1:0] D_P1  = CW'(DEPTH + 1);
  localparam logic [CW-1:0] D_X2  = CW'(2 * DEPTH);

  always_comb begin
    s_en = 1'b0; s_we = 1'b0; s_addr = '0; s_wdata = '0;
    h_en = 1'b0; h_we = 1'b0; h_addr = '0; h_wdata = '0;
    unique case (state)
      ST_READY: begin
        s_en    = acc;
        s_we    = acc & req_we;
        s_addr  = req_addr;
        s_wdata = req_wdata;
      end
      ST_RECALL: begin
        if (cnt < D_C) begin
          // phase one: zero each word
          s_en   = 1'b1;
          s_we   = 1'b1;
          s_addr = cnt[AW-1:0];
        end else begin
          // phase two: shadow read issued one cycle ahead of the SRAM write
          if (cnt < D_X2) begin
            h_en   = 1'b1;
            h_addr = AW'(cnt - D_C);
          end
          if (cnt > D_C && cnt <= D_X2) begin
            s_en    = 1'b1;
            s_we    = 1'b1;
            s_addr  = AW'(cnt - D_P1);
            s_wdata = h_rdata;
          end
        end
      end
      ST_STORE: begin
        if (cnt < D_C) begin
          s_en   = 1'b1;
          s_addr = cnt[AW-1:0];
        end
        if (cnt != '0 && cnt <= D_C) begin
          h_en    = 1'b1;
          h_we    = 1'b1;
          h_addr  = AW'(cnt - CW'(1));
          h_wdata = s_rdata;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int AW       = 3,
  parameter int DW       = 8,
  parameter int T_STORE  = 12,   // >= 2**AW + 1
  parameter int T_RECALL = 20    // >= 2 * 2**AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_ok,
  input  logic          pwr_low,
  input  logic          sw_store,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata
);
  localparam int TMAX = (T_STORE > T_RECALL) ? T_STORE : T_RECALL;
  localparam int CW   = $clog2(TMAX + 1);

  nvs_state_e    seq_state;
  logic [CW-1:0] seq_cnt;
  logic          seq_busy, seq_dirty;
  logic          acc;
  logic          s_en, s_we, h_en, h_we;
  logic [AW-1:0] s_addr, h_addr;
  logic [DW-1:0] s_wdata, h_wdata, s_rdata, h_rdata;
  logic          rsp_q;

  assign acc = req_valid & ~seq_busy;

  nvs_seq #(.T_STORE(T_STORE), .T_RECALL(T_RECALL), .CW(CW)) u_seq (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .pwr_low(pwr_low),
    .sw_store(sw_store), .acc_wr(acc & req_we),
    .state(seq_state), .cnt(seq_cnt), .busy(seq_busy), .dirty(seq_dirty)
  );

  nvs_xfer #(.AW(AW), .DW(DW), .CW(CW)) u_xfer (
    .state(seq_state), .cnt(seq_cnt), .acc(acc), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .s_rdata(s_rdata), .h_rdata(h_rdata),
    .s_en(s_en), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
    .h_en(h_en), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata)
  );

  nvs_spram #(.AW(AW), .DW(DW)) u_sram (
    .clk(clk), .en(s_en), .we(s_we), .addr(s_addr),
    .wdata(s_wdata), .rdata(s_rdata)
  );

  nvs_spram #(.AW(AW), .DW(DW)) u_shadow (
    .clk(clk), .en(h_en), .we(h_we), .addr(h_addr),
    .wdata(h_wdata), .rdata(h_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) rsp_q <= 1'b0;
    else     rsp_q <= acc;
  end

  assign busy      = seq_busy;
  assign rsp_ready = rsp_q;
  assign rsp_rdata = s_rdata;
endmodule

// File: rtl/nvs_ctrl_chk.sv
module nvs_ctrl_chk
  import nvs_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       pwr_ok,
  input logic       pwr_low,
  input logic       req_valid,
  input logic       req_we,
  input logic       busy,
  input logic       rsp_ready,
  input logic       dirty,
  input nvs_state_e state
);
  p_refuse_busy_r3: assert property (@(posedge clk) disable iff (rst)
    busy |=> !rsp_ready);

  p_accept_r4: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid) |=> rsp_ready);

  p_no_spurious_r4: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_ready);

  p_lowsupply_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && !pwr_ok && !$past(pwr_ok) && !pwr_low) |=> !busy);

  p_dirty_fall_stores_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy && $fell(pwr_ok) && dirty) |=> busy);

  p_clean_fall_skips_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy && $fell(pwr_ok) && !dirty && !(req_valid && req_we) && !pwr_low) |=> !busy);

  p_write_marks_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid && req_we) |=> dirty);

  p_brownout_busy_r9: assert property (@(posedge clk) disable iff (rst)
    pwr_low |=> busy);

  p_wait_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && (!pwr_ok || pwr_low)) |=> state == ST_WAIT);
endmodule

bind nvs_ctrl nvs_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .pwr_low(pwr_low),
  .req_valid(req_valid), .req_we(req_we), .busy(busy),
  .rsp_ready(rsp_ready), .dirty(seq_dirty), .state(seq_state)
);

// File: tb/nvs_ctrl_test.sv
module nvs_ctrl_test;
  localparam int CLK_P = 10;
  localparam int AW    = 3;
  localparam int DW    = 8;
  localparam int T_ST  = 12;
  localparam int T_RC  = 20;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst = 1'b1;
  logic pwr_ok = 1'b0, pwr_low = 1'b0, sw_store = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic busy, rsp_ready;
  logic [DW-1:0] rsp_rdata;

  int total = 0, bad = 0;
  logic [DW-1:0] sram_m [DEPTH];
  logic [DW-1:0] shd_m  [DEPTH];
  bit dirty_m = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  nvs_ctrl #(.AW(AW), .DW(DW), .T_STORE(T_ST), .T_RECALL(T_RC)) uut (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .pwr_low(pwr_low),
    .sw_store(sw_store), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  function automatic logic [DW-1:0] pattern(int a, int s);
    return DW'(a * 37 + s * 11 + 5);
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic access(bit we, int a, logic [DW-1:0] d, string tag);
    req_valid = 1'b1; req_we = we; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    chk({tag, " (R4 accept)"}, rsp_ready, 1);
    if (!we) chk({tag, " data"}, rsp_rdata, sram_m[a]);
    else begin sram_m[a] = d; dirty_m = 1'b1; end
  endtask

  task automatic read_all(string tag);
    for (int a = 0; a < DEPTH; a++) access(1'b0, a, '0, tag);
  endtask

  // counts edges until busy drops, firing refused writes while busy (R3)
  task automatic wait_busy(int exp, string tag);
    int n = 0;
    bit drove = 1'b0;
    do begin
      @(negedge clk);
      n++;
      sw_store = 1'b0;
      if (drove) chk("R3 request refused while busy", rsp_ready, 0);
      if (busy) begin
        req_valid = 1'b1; req_we = 1'b1;
        req_addr = AW'($urandom); req_wdata = DW'($urandom);
        drove = 1'b1;
      end else begin
        req_valid = 1'b0; req_we = 1'b0;
      end
    end while (busy && n < 5000);
    req_valid = 1'b0; req_we = 1'b0;
    chk(tag, n, exp);
  endtask

  task automatic backup_model();
    for (int a = 0; a < DEPTH; a++) shd_m[a] = sram_m[a];
    dirty_m = 1'b0;
  endtask

  task automatic restore_model();
    for (int a = 0; a < DEPTH; a++) sram_m[a] = shd_m[a];
    dirty_m = 1'b0;
  endtask

  task automatic do_sw_store(string tag);
    sw_store = 1'b1;
    if (pwr_ok) begin
      wait_busy(T_ST + 1, tag);
      backup_model();
    end else begin
      @(negedge clk);
      sw_store = 1'b0;
      chk("R6 sw store ignored at low supply", busy, 0);
    end
  endtask

  task automatic power_down(bit go_low, string clean_tag);
    pwr_ok = 1'b0;
    if (dirty_m) begin
      wait_busy(T_ST + 1, "R7 dirty fall runs backup");
      backup_model();
    end else begin
      @(negedge clk);
      chk(clean_tag, busy, 0);
    end
    if (go_low) begin
      pwr_low = 1'b1;
      @(negedge clk);
      chk("R9 brownout latches restore", busy, 1);
      pwr_ok = 1'b1;
      repeat (3) begin
        @(negedge clk);
        chk("R9 restore held while below reset", busy, 1);
      end
      pwr_low = 1'b0;
      wait_busy(T_RC + 1, "R2 restore duration");
      restore_model();
    end else begin
      pwr_ok = 1'b1;
      repeat (3) begin
        @(negedge clk);
        chk("R9 no restore without brownout", busy, 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 busy after reset", busy, 1);
    chk("R1 no response after reset", rsp_ready, 0);
    req_valid = 1'b1; req_we = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk("R3 access refused before power-up", rsp_ready, 0);
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk("R1 stays busy without supply", busy, 1);
    pwr_ok = 1'b1;
    wait_busy(T_RC + 1, "R1 power-up restore duration");
    dirty_m = 1'b0;

    for (int a = 0; a < DEPTH; a++) access(1'b1, a, pattern(a, 1), "R4 write");
    read_all("R4 read back");
    do_sw_store("R5 sw backup duration");

    for (int a = 0; a < 4; a++) access(1'b1, a, pattern(a, 2), "R4 write");
    power_down(1'b1, "R7 clean fall");
    read_all("R2 restored contents");
    power_down(1'b1, "R8 clean after backup");
    read_all("R2 repeated restore");

    // low supply, no brownout: accesses still served, sw backup ignored
    pwr_ok = 1'b0;
    @(negedge clk);
    chk("R8 clean after restore skips backup", busy, 0);
    access(1'b1, 5, pattern(5, 9), "R4 write at low supply");
    do_sw_store("R6 unused");
    pwr_low = 1'b1;
    @(negedge clk);
    chk("R9 brownout latches restore", busy, 1);
    pwr_low = 1'b0;
    pwr_ok  = 1'b1;
    wait_busy(T_RC + 1, "R2 restore duration");
    restore_model();
    read_all("R6 shadow unchanged by ignored backup");
    do_sw_store("R5 backup with no writes");
    power_down(1'b0, "R8 fall after backup skips");

    for (int i = 0; i < 200; i++) begin
      int op = int'($urandom % 10);
      int a  = int'($urandom % DEPTH);
      if (op < 4)       access(1'b1, a, DW'($urandom), "R4 random write");
      else if (op < 7)  access(1'b0, a, '0, "R4 random read");
      else if (op == 7) do_sw_store("R5 random backup duration");
      else if (op == 8) power_down(1'b1, "R7 random clean fall");
      else              power_down(1'b0, "R7 random clean fall");
    end
    read_all("R2 final contents");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule